// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This block sits beside a memory ECC decoder. Each cycle the decoder may report one error event, marked as either correctable or uncorrectable. The event carries the failing address (34 bits), the 64-bit data word, an 8-bit syndrome and a 14-bit requester ID. The unit keeps one capture set per class. The first event of a class is recorded and flagged. Later events of that class only mark an overflow, and the recorded values stay untouched until software acknowledges the class.

Software reaches the unit through a 32-bit register port with separate read and write strobes and byte addresses. Through this port it enables capture, reads status and the captured values, clears status by writing ones, and masks the interrupt. The masks are a per-status-bit ECC mask, a group mask in which bit 2 is the ECC group, and a global bit 31. When both classes are pending, the intended service order is correctable first.

Top module: `ecc_capture_unit`

## Requirements
- R1: After reset, status (0x04) reads 0, control (0x00) reads 0, the group mask (0x0C) reads 0xFFFFFFFF, the ECC mask (0x10) reads 0, and `irq` and `reg_rdata` are 0.
- R2: Capture is enabled while at least one of control bits 17:16 is set. While both are 0, events change neither status nor capture registers.
- R3: An enabled event of a class whose two status bits are both 0 sets the low bit of the class field (status bit 0 for correctable, bit 2 for uncorrectable). In the same edge it records the address, data, syndrome and requester ID.
- R4: While either status bit of a class is set, further events of that class leave its capture registers unchanged and set the high bit of the field (bit 1 correctable, bit 3 uncorrectable). The other class is unaffected.
- R5: Writing to the acknowledge register (0x08) clears each status bit whose write-data bit 3:0 is 1. An event arriving in the same cycle is judged against the status as it was before that acknowledge.
- R6: Capture registers lie at base 0x20 (correctable) and 0x40 (uncorrectable). Address bits 31:0 are at +0x00, address bits 33:32 are in bits 1:0 of +0x04, data bits 31:0 are at +0x08, data bits 63:32 are at +0x0C, and the syndrome is in bits 15:8 of +0x10.
- R7: Register 0x60 holds the correctable requester ID in bits 29:16 and the uncorrectable requester ID in bits 13:0.
- R8: `irq` rises one cycle after any status bit that is not masked in the ECC mask (bit n masks status bit n) becomes set, provided group-mask bits 2 and 31 are clear. It falls one cycle after that condition ends.
- R9: While group-mask bit 31 is set, `irq` is low in the following cycle, whatever the status.
- R10: `reg_rdata` updates one cycle after `reg_re` and holds its value in cycles without `reg_re`. Unmapped addresses and the acknowledge register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Decoder reports an error this cycle |
| ev_uncorr | input | 1 | 1: uncorrectable, 0: correctable |
| ev_addr | input | 34 | Failing address |
| ev_data | input | 64 | Data word of the failing access |
| ev_synd | input | 8 | Syndrome |
| ev_src | input | 14 | Requester ID |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that the decoder raises at most one event per cycle and that reset is applied before any strobe. They also assume that a read and a write never target the same cycle. The stimulus keeps to these limits: every cycle carries at most one read, one write and one event. Random cycles mix events of both classes with acknowledges, sometimes in the same cycle, while the mask and enable settings are also changed at random. Directed cases cover the disabled state, overflow marking, same-cycle acknowledge, and each mask level.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_ACK   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_GMASK = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_EMASK = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CE    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_UE    = 8'h40;
  localparam logic [REG_AW-1:0] OFS_SRC   = 8'h60;

  localparam logic [REG_AW-1:0] SUB_ALO = 8'h00;
  localparam logic [REG_AW-1:0] SUB_AHI = 8'h04;
  localparam logic [REG_AW-1:0] SUB_DLO = 8'h08;
  localparam logic [REG_AW-1:0] SUB_DHI = 8'h0C;
  localparam logic [REG_AW-1:0] SUB_SYN = 8'h10;

  localparam int EN_LSB     = 16;
  localparam int SYN_LSB    = 8;
  localparam int SRC_CE_LSB = 16;
  localparam int GMASK_ECC  = 2;
  localparam int GMASK_ALL  = 31;

  localparam int NUM_CLS = 2;

  typedef enum logic {CLS_CORR = 1'b0, CLS_UNCORR = 1'b1} ecc_cls_e;
endpackage

// File: rtl/ecc_cap_class.sv
module ecc_cap_class #(
  parameter int AW = 34,
  parameter int DW = 64,
  parameter int SW = 8,
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          ev_i,
  input  logic [1:0]    ack_i,
  input  logic [AW-1:0] ev_addr_i,
  input  logic [DW-1:0] ev_data_i,
  input  logic [SW-1:0] ev_synd_i,
  input  logic [IW-1:0] ev_src_i,
  output logic [1:0]    fld_o,
  output logic [AW-1:0] cap_addr_o,
  output logic [DW-1:0] cap_data_o,
  output logic [SW-1:0] cap_synd_o,
  output logic [IW-1:0] cap_src_o
);
  logic [1:0]    fld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [SW-1:0] synd_q;
  logic [IW-1:0] src_q;
  logic          take, drop;

  assign take = en_i && ev_i && (fld_q == 2'b00);
  assign drop = en_i && ev_i && (fld_q != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      synd_q <= '0;
      src_q  <= '0;
    end else begin
      fld_q <= (fld_q & ~ack_i) | {drop, take};
      if (take) begin
        addr_q <= ev_addr_i;
        data_q <= ev_data_i;
        synd_q <= ev_synd_i;
        src_q  <= ev_src_i;
      end
    end
  end

  assign fld_o      = fld_q;
  assign cap_addr_o = addr_q;
  assign cap_data_o = data_q;
  assign cap_synd_o = synd_q;
  assign cap_src_o  = src_q;

  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ((fld_q & ~$past(fld_q)) == 2'b00)); // R2
  AST_FIRST_SETS_LOW: assert property (@(posedge clk) disable iff (rst)
    (en_i && ev_i && fld_q == 2'b00) |=> fld_q[0]); // R3
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (fld_q != 2'b00) |=> ($stable(addr_q) && $stable(data_q) && $stable(synd_q) && $stable(src_q))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i[0] && !ev_i) |=> !fld_q[0]); // R5
endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] stat_i,
  input  logic [NS-1:0] emask_i,
  input  logic          grp_mask_i,
  input  logic          gmask_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= !gmask_i && !grp_mask_i && |(stat_i & ~emask_i);
  end

  assign irq_o = irq_q;

  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (rst)
    gmask_i |=> !irq_o); // R9
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    ((stat_i & ~emask_i) == '0) |=> !irq_o); // R8
endmodule

// File: rtl/ecc_cap_rdmux.sv
module ecc_cap_rdmux
  import ecc_cap_pkg::*;
#(
  parameter int AW = 34,
  parameter int DW = 64,
  parameter int SW = 8,
  parameter int IW = 14
) (
  input  logic [REG_AW-1:0]             rd_addr_i,
  input  logic [1:0]                    en_i,
  input  logic [2*NUM_CLS-1:0]          stat_i,
  input  logic [REG_DW-1:0]             gmask_i,
  input  logic [2*NUM_CLS-1:0]          emask_i,
  input  logic [NUM_CLS-1:0][AW-1:0]    caddr_i,
  input  logic [NUM_CLS-1:0][DW-1:0]    cdata_i,
  input  logic [NUM_CLS-1:0][SW-1:0]    csynd_i,
  input  logic [NUM_CLS-1:0][IW-1:0]    csrc_i,
  output logic [REG_DW-1:0]             rd_val_o
);
  localparam int AHW = AW - 32;
  localparam int DHW = DW - 32;

  always_comb begin
    rd_val_o = '0;
    unique case (rd_addr_i)
      OFS_CTRL:  rd_val_o[EN_LSB +: 2] = en_i;
      OFS_STAT:  rd_val_o[2*NUM_CLS-1:0] = stat_i;
      OFS_GMASK: rd_val_o = gmask_i;
      OFS_EMASK: rd_val_o[2*NUM_CLS-1:0] = emask_i;
      OFS_SRC: begin
        rd_val_o[SRC_CE_LSB +: IW] = csrc_i[CLS_CORR];
        rd_val_o[0 +: IW]          = csrc_i[CLS_UNCORR];
      end
      default: rd_val_o = '0;
    endcase
    for (int c = 0; c < NUM_CLS; c++) begin
      logic [REG_AW-1:0] base;
      base = (c == 0) ? OFS_CE : OFS_UE;
      if (rd_addr_i == base + SUB_ALO) rd_val_o = caddr_i[c][31:0];
      if (rd_addr_i == base + SUB_AHI) begin
        rd_val_o = '0;
        rd_val_o[AHW-1:0] = caddr_i[c][AW-1:32];
      end
      if (rd_addr_i == base + SUB_DLO) rd_val_o = cdata_i[c][31:0];
      if (rd_addr_i == base + SUB_DHI) begin
        rd_val_o = '0;
        rd_val_o[DHW-1:0] = cdata_i[c][DW-1:32];
      end
      if (rd_addr_i == base + SUB_SYN) begin
        rd_val_o = '0;
        rd_val_o[SYN_LSB +: SW] = csynd_i[c];
      end
    end
  end
endmodule

// File: rtl/ecc_capture_unit.sv
module ecc_capture_unit
  import ecc_cap_pkg::*;
#(
  parameter int AW = 34,
  parameter int DW = 64,
  parameter int SW = 8,
  parameter int IW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_uncorr,
  input  logic [AW-1:0]     ev_addr,
  input  logic [DW-1:0]     ev_data,
  input  logic [SW-1:0]     ev_synd,
  input  logic [IW-1:0]     ev_src,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);
  localparam int NS = 2 * NUM_CLS;

  logic [1:0]                 ctrl_en_q;
  logic [REG_DW-1:0]          gmask_q;
  logic [NS-1:0]              emask_q;
  logic [REG_DW-1:0]          rdata_q;
  logic [NS-1:0]              ack_bits;
  logic [NS-1:0]              stat;
  logic                       cap_en;
  logic [REG_DW-1:0]          rd_val;
  logic [NUM_CLS-1:0][1:0]    fld;
  logic [NUM_CLS-1:0][AW-1:0] caddr;
  logic [NUM_CLS-1:0][DW-1:0] cdata;
  logic [NUM_CLS-1:0][SW-1:0] csynd;
  logic [NUM_CLS-1:0][IW-1:0] csrc;

  assign cap_en   = |ctrl_en_q;
  assign ack_bits = (reg_we && reg_addr == OFS_ACK) ? reg_wdata[NS-1:0] : '0;
  assign stat     = fld;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= '0;
      gmask_q   <= '1;
      emask_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr == OFS_CTRL)  ctrl_en_q <= reg_wdata[EN_LSB +: 2];
        if (reg_addr == OFS_GMASK) gmask_q   <= reg_wdata;
        if (reg_addr == OFS_EMASK) emask_q   <= reg_wdata[NS-1:0];
      end
      if (reg_re) rdata_q <= rd_val;
    end
  end

  assign reg_rdata = rdata_q;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    localparam logic IS_UE = (g == 1);
    ecc_cap_class #(.AW(AW), .DW(DW), .SW(SW), .IW(IW)) u_cls (
      .clk        (clk),
      .rst        (rst),
      .en_i       (cap_en),
      .ev_i       (ev_valid && (ev_uncorr == IS_UE)),
      .ack_i      (ack_bits[2*g +: 2]),
      .ev_addr_i  (ev_addr),
      .ev_data_i  (ev_data),
      .ev_synd_i  (ev_synd),
      .ev_src_i   (ev_src),
      .fld_o      (fld[g]),
      .cap_addr_o (caddr[g]),
      .cap_data_o (cdata[g]),
      .cap_synd_o (csynd[g]),
      .cap_src_o  (csrc[g])
    );
  end

  ecc_cap_rdmux #(.AW(AW), .DW(DW), .SW(SW), .IW(IW)) u_rdmux (
    .rd_addr_i (reg_addr),
    .en_i      (ctrl_en_q),
    .stat_i    (stat),
    .gmask_i   (gmask_q),
    .emask_i   (emask_q),
    .caddr_i   (caddr),
    .cdata_i   (cdata),
    .csynd_i   (csynd),
    .csrc_i    (csrc),
    .rd_val_o  (rd_val)
  );

  ecc_cap_irq #(.NS(NS)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .stat_i     (stat),
    .emask_i    (emask_q),
    .grp_mask_i (gmask_q[GMASK_ECC]),
    .gmask_i    (gmask_q[GMASK_ALL]),
    .irq_o      (irq)
  );

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata)); // R10
endmodule

// File: tb/tb_ecc_capture_unit.sv
`timescale 1ns/1ps
module tb_ecc_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0, ev_uncorr = 1'b0;
  logic [33:0] ev_addr = '0;
  logic [63:0] ev_data = '0;
  logic [7:0]  ev_synd = '0;
  logic [13:0] ev_src = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench model
  logic [1:0]  m_f [2];
  logic [33:0] m_a [2];
  logic [63:0] m_d [2];
  logic [7:0]  m_s [2];
  logic [13:0] m_i [2];
  logic [1:0]  m_en;
  logic [31:0] m_gm;
  logic [3:0]  m_em;

  always #2.5 clk = ~clk;

  ecc_capture_unit dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_synd(ev_synd), .ev_src(ev_src),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h00: v[17:16] = m_en;
      8'h04: v[3:0] = {m_f[1], m_f[0]};
      8'h0C: v = m_gm;
      8'h10: v[3:0] = m_em;
      8'h60: begin v[29:16] = m_i[0]; v[13:0] = m_i[1]; end
      default: v = '0;
    endcase
    for (int c = 0; c < 2; c++) begin
      logic [7:0] b = (c == 0) ? 8'h20 : 8'h40;
      if (a == b)         v = m_a[c][31:0];
      if (a == b + 8'h04) v = {30'b0, m_a[c][33:32]};
      if (a == b + 8'h08) v = m_d[c][31:0];
      if (a == b + 8'h0C) v = m_d[c][63:32];
      if (a == b + 8'h10) v = {16'b0, m_s[c], 8'b0};
    end
    return v;
  endfunction

  function automatic logic exp_irq();
    return !m_gm[31] && !m_gm[2] && |({m_f[1], m_f[0]} & ~m_em);
  endfunction

  function automatic logic [7:0] pick_addr(input int k);
    case (k % 15)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h0C;  3: return 8'h10;
      4: return 8'h20;  5: return 8'h24;  6: return 8'h28;  7: return 8'h2C;
      8: return 8'h30;  9: return 8'h40;  10: return 8'h44; 11: return 8'h48;
      12: return 8'h4C; 13: return 8'h50; default: return 8'h60;
    endcase
  endfunction

  // one clock cycle; drives at negedge, returns at next negedge with model updated
  task automatic cyc(input logic we, input logic re, input logic [7:0] a, input logic [31:0] wd,
                     input logic ev, input logic uc, input logic [33:0] ea,
                     input logic [63:0] ed, input logic [7:0] es, input logic [13:0] ei);
    logic [1:0] setb [2];
    logic [3:0] ack;
    int c;
    reg_we = we; reg_re = re; reg_addr = a; reg_wdata = wd;
    ev_valid = ev; ev_uncorr = uc; ev_addr = ea; ev_data = ed; ev_synd = es; ev_src = ei;
    @(negedge clk);
    setb[0] = 2'b00; setb[1] = 2'b00;
    c = uc ? 1 : 0;
    if (ev && m_en != 2'b00) begin
      if (m_f[c] == 2'b00) begin
        setb[c] = 2'b01;
        m_a[c] = ea; m_d[c] = ed; m_s[c] = es; m_i[c] = ei;
      end else setb[c] = 2'b10;
    end
    ack = (we && a == 8'h08) ? wd[3:0] : 4'h0;
    m_f[0] = (m_f[0] & ~ack[1:0]) | setb[0];
    m_f[1] = (m_f[1] & ~ack[3:2]) | setb[1];
    if (we && a == 8'h00) m_en = wd[17:16];
    if (we && a == 8'h0C) m_gm = wd;
    if (we && a == 8'h10) m_em = wd[3:0];
    reg_we = 0; reg_re = 0; ev_valid = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic ev(input logic uc, input logic [33:0] ea, input logic [63:0] ed,
                    input logic [7:0] es, input logic [13:0] ei);
    cyc(0, 0, 8'h00, 0, 1, uc, ea, ed, es, ei);
  endtask
  task automatic chk_rd(input string req, input logic [7:0] a);
    logic [31:0] e = exp_rd(a);
    cyc(0, 1, a, 0, 0, 0, 0, 0, 0, 0);
    chk(req, reg_rdata, e);
  endtask
  task automatic chk_irq(input string req);
    idle();
    chk(req, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240517));
    for (int c = 0; c < 2; c++) begin
      m_f[c] = 0; m_a[c] = 0; m_d[c] = 0; m_s[c] = 0; m_i[c] = 0;
    end
    m_en = 0; m_gm = 32'hFFFF_FFFF; m_em = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    chk_rd("R1 status", 8'h04);
    chk("R1 status literal", reg_rdata, 32'h0);
    chk_rd("R1 group mask", 8'h0C);
    chk("R1 group mask literal", reg_rdata, 32'hFFFF_FFFF);
    chk_rd("R1 control", 8'h00);
    chk_rd("R1 ecc mask", 8'h10);

    // R2 disabled capture
    ev(0, 34'h1_0000_0001, 64'h11, 8'h11, 14'h11);
    ev(1, 34'h1_0000_0002, 64'h22, 8'h22, 14'h22);
    chk_rd("R2 status unchanged while disabled", 8'h04);
    chk("R2 status literal", reg_rdata, 32'h0);
    chk_rd("R2 capture untouched", 8'h20);

    // R3 first correctable capture, enable with only bit 16
    wr(8'h00, 32'h0001_0000);
    ev(0, 34'h3_1234_5678, 64'hDEAD_BEEF_CAFE_F00D, 8'hA5, 14'h1ABC);
    chk_rd("R3 status low bit", 8'h04);
    chk("R3 status literal", reg_rdata, 32'h1);
    chk_rd("R6 ce addr lo", 8'h20);
    chk("R6 ce addr lo literal", reg_rdata, 32'h1234_5678);
    chk_rd("R6 ce addr hi", 8'h24);
    chk("R6 ce addr hi literal", reg_rdata, 32'h3);
    chk_rd("R6 ce data lo", 8'h28);
    chk("R6 ce data hi literal", exp_rd(8'h2C), 32'hDEAD_BEEF);
    chk_rd("R6 ce data hi", 8'h2C);
    chk_rd("R6 ce syndrome", 8'h30);
    chk("R6 ce syndrome literal", reg_rdata, 32'h0000_A500);
    chk_rd("R7 source id", 8'h60);
    chk("R7 source id literal", reg_rdata, 32'h1ABC_0000);

    // R4 overflow on second correctable event
    ev(0, 34'h0_0000_0ABC, 64'h5, 8'h01, 14'h0005);
    chk_rd("R4 overflow bit", 8'h04);
    chk("R4 status literal", reg_rdata, 32'h3);
    chk_rd("R4 capture frozen", 8'h20);
    chk("R4 capture frozen literal", reg_rdata, 32'h1234_5678);

    // R8/R9 interrupt masking
    chk_irq("R9 global mask at reset value");
    wr(8'h0C, 32'h7FFF_FFFB);
    idle();
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h3);
    chk_irq("R8 ecc mask hides correctable");
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFB);
    chk_irq("R9 global bit set");
    wr(8'h0C, 32'h7FFF_FFFF);
    chk_irq("R8 group bit 2 masks");
    wr(8'h0C, 32'h7FFF_FFFB);
    chk_irq("R8 irq back");

    // uncorrectable capture, independent class
    ev(1, 34'h2_8765_4321, 64'h0123_4567_89AB_CDEF, 8'h3C, 14'h2001);
    chk_rd("R4 classes independent", 8'h04);
    chk("R4 status literal both", reg_rdata, 32'h7);
    chk_rd("R6 ue addr lo", 8'h40);
    chk_rd("R6 ue addr hi", 8'h44);
    chk_rd("R6 ue data lo", 8'h48);
    chk_rd("R6 ue data hi", 8'h4C);
    chk_rd("R6 ue syndrome", 8'h50);
    chk_rd("R7 both ids", 8'h60);
    chk("R7 both ids literal", reg_rdata, 32'h1ABC_2001);

    // R5 acknowledge
    wr(8'h08, 32'h1);
    chk_rd("R5 ack low bit", 8'h04);
    chk("R5 status literal", reg_rdata, 32'h6);
    ev(0, 34'h0_0000_0777, 64'h7, 8'h07, 14'h0007);
    chk_rd("R4 still frozen with overflow only", 8'h20);
    wr(8'h08, 32'h2);
    ev(0, 34'h1_AAAA_5555, 64'h9, 8'h99, 14'h0999);
    chk_rd("R3 recapture after ack", 8'h20);
    chk("R3 recapture literal", reg_rdata, 32'hAAAA_5555);

    // R5 same-cycle ack and event
    cyc(1, 0, 8'h08, 32'hC, 1, 1, 34'h5, 64'h5, 8'h5, 14'h5);
    chk_rd("R5 same-cycle event judged pre-ack", 8'h04);
    chk("R5 same-cycle literal", reg_rdata, 32'h9);
    chk_rd("R5 ue capture kept", 8'h40);
    wr(8'h08, 32'hF);
    chk_rd("R5 all cleared", 8'h04);
    chk_irq("R8 irq falls");

    // R10 read port
    chk_rd("R10 unmapped", 8'h7C);
    chk_rd("R10 ack reads zero", 8'h08);
    chk_rd("R10 load", 8'h0C);
    held = reg_rdata;
    idle();
    idle();
    chk("R10 hold", reg_rdata, held);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 8;
      logic [33:0] ra = {$urandom, $urandom};
      logic [63:0] rd = {$urandom, $urandom};
      case (op)
        0, 1: ev($urandom % 2, ra, rd, $urandom, $urandom);
        2: wr(8'h08, $urandom % 16);
        3: cyc(1, 0, 8'h08, $urandom % 16, 1, $urandom % 2, ra, rd, $urandom, $urandom);
        4: chk_rd("R3 R4 R6 R7 random read", pick_addr($urandom));
        5: wr(8'h10, $urandom % 16);
        6: begin
          int k = $urandom % 4;
          if (k == 0) wr(8'h00, ($urandom % 4) << 16);
          else if (k == 1) wr(8'h0C, (($urandom % 2) << 31) | (($urandom % 2) << 2) | 32'h7FFF_FFFB);
          else chk_rd("R5 random status", 8'h04);
        end
        default: chk_irq("R8 R9 random irq");
      endcase
      if (it % 50 == 0) wr(8'h00, 32'h0003_0000);
    end
    chk_rd("R2 final control", 8'h00);
    finish_run();
  end
endmodule